// File: doc/BRIEF.md
# Clock Mode Switch Sequencer

This block changes the system clock mode without corrupting external SDRAM. A request carries a 4-bit target mode. The sequencer first masks interrupts. It then asks the SDRAM controller to enter self-refresh and waits until the controller confirms it. Next it writes the target mode into the mode register word and fires a single-cycle switch-enable write to the clock-control register, keeping every other field of that register as it is.

After the switch it holds self-refresh for a fixed settling interval so the clock can stabilise. It then releases self-refresh, waits until the controller reports that self-refresh has ended, and restores the interrupt enable that was in force when the request was taken. A one-cycle done pulse closes the sequence.

Each acknowledge wait has a timeout. If the controller never confirms entry, the sequencer skips the clock switch and releases self-refresh. If the controller never confirms exit, the sequencer gives up waiting. In both cases it sets a sticky error flag and still restores interrupts and pulses done. The clock generator, the SDRAM command logic and cache maintenance sit outside this block.

Top module: `clk_mode_seq`

## Requirements
- R1: After reset, done_o, err_o, sr_req_o, mode_we_o and ctl_we_o are 0, and while idle irq_en_o follows irq_en_i.
- R2: A request is taken on a clock edge where req_i is 1 and the block is idle. In the following cycle irq_en_o is 0 while sr_req_o is still 0. irq_en_o stays 0 in every cycle in which sr_req_o is 1.
- R3: mode_we_o is asserted only after sr_ack_i has been seen at 1 while self-refresh is requested.
- R4: mode_we_o is high for one cycle, and mode_wdata_o then carries the request's mode in bits 27:24 with all other bits 0. The mode is the value of req_mode_i on the edge where the request was taken; later changes of req_mode_i have no effect.
- R5: ctl_we_o is high for exactly one cycle, in the cycle right after mode_we_o. ctl_wdata_o then equals ctl_cur_i with bit 31 (switch enable) set and bits 30:0 unchanged.
- R6: After the ctl_we_o cycle, sr_req_o stays 1 for exactly SETTLE_CYCLES further cycles (256 by default) and then drops to 0.
- R7: done_o is a one-cycle pulse. On a sequence without error it comes only after sr_ack_i has been seen at 0 following the release. In the done cycle irq_en_o equals the irq_en_i value captured when the request was taken.
- R8: A request that arrives while a sequence is in progress is ignored. Each accepted request gives exactly one done pulse and at most one ctl_we_o pulse.
- R9: If sr_ack_i does not rise within ACK_TIMEOUT cycles of waiting for entry, err_o is set and sr_req_o drops. Neither mode_we_o nor ctl_we_o is asserted, and done_o still pulses. sr_req_o is high for 1 + ACK_TIMEOUT cycles in total.
- R10: If sr_ack_i does not fall within ACK_TIMEOUT cycles of waiting for exit, err_o is set and the sequence still ends with a done pulse.
- R11: err_o is sticky: once set, it stays 1 until reset, including through later sequences that succeed.
- R12: The internal sequence state is one-hot at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Mode change request |
| req_mode_i | input | 4 | Target clock mode |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky acknowledge-timeout flag |
| irq_en_i | input | 1 | Current global interrupt enable |
| irq_en_o | output | 1 | Gated global interrupt enable |
| sr_req_o | output | 1 | Self-refresh request to the SDRAM controller |
| sr_ack_i | input | 1 | Self-refresh active status from the SDRAM controller |
| mode_we_o | output | 1 | Write strobe for the mode register word |
| mode_wdata_o | output | 32 | Mode register word (mode in bits 27:24) |
| ctl_cur_i | input | 32 | Current clock-control register contents |
| ctl_we_o | output | 1 | Write strobe for the clock-control register |
| ctl_wdata_o | output | 32 | Clock-control word with switch enable (bit 31) set |

## Verification
The assertions assume that sr_ack_i is a clean level from the SDRAM controller. It is expected to rise only while self-refresh is requested and to fall only once the request is withdrawn. Under that assumption, seeing the acknowledge high on the cycle before mode_we_o, and low when done_o fires, really does mean the handshake completed. The bench keeps within this assumption by modelling the controller as a delayed copy of sr_req_o. It breaks the assumption only on purpose, by holding the acknowledge stuck low or stuck high, to exercise the two timeout paths. In those runs the assertions that depend on a completed handshake are qualified by err_o.

// File: rtl/cms_pkg.sv
package cms_pkg;
  localparam int REG_W     = 32;
  localparam int MODE_W    = 4;
  localparam int MODE_LSB  = 24;
  localparam int SW_EN_BIT = 31;

  localparam int NUM_ST      = 10;
  localparam int I_IDLE      = 0;
  localparam int I_IRQ_OFF   = 1;
  localparam int I_SR_REQ    = 2;
  localparam int I_SR_WAIT   = 3;
  localparam int I_SET_MODE  = 4;
  localparam int I_SWITCH    = 5;
  localparam int I_SETTLE    = 6;
  localparam int I_SR_EXIT   = 7;
  localparam int I_EXIT_WAIT = 8;
  localparam int I_RESTORE   = 9;

  typedef logic [NUM_ST-1:0] seq_state_t;

  // Place the target mode in its field of the mode register word.
  function automatic logic [REG_W-1:0] mode_word(input logic [MODE_W-1:0] m);
    logic [REG_W-1:0] w;
    w = '0;
    w[MODE_LSB +: MODE_W] = m;
    return w;
  endfunction

  // Keep every clock-control field and raise the switch-enable bit.
  function automatic logic [REG_W-1:0] ctl_word(input logic [REG_W-1:0] cur);
    logic [REG_W-1:0] w;
    w = cur;
    w[SW_EN_BIT] = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/cms_cycle_timer.sv
module cms_cycle_timer #(
  parameter int LIMIT = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output logic hit_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign hit_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (en_i && !hit_o)   cnt_q <= cnt_q + 1'b1;
  end

  // R6 R9 R10
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/cms_seq_fsm.sv
module cms_seq_fsm
  import cms_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              irq_en_i,
  input  logic              sr_ack_i,
  input  logic              settle_hit_i,
  input  logic              ack_tmo_i,
  output seq_state_t        state_o,
  output logic [MODE_W-1:0] mode_q_o,
  output logic              irq_saved_o,
  output logic              err_o
);
  seq_state_t st_q, st_d;
  logic       accept;
  logic       entry_tmo;
  logic       exit_tmo;
  logic [MODE_W-1:0] mode_q;
  logic       irq_saved_q;
  logic       err_q;

  assign accept    = st_q[I_IDLE] && req_i;
  assign entry_tmo = st_q[I_SR_WAIT] && !sr_ack_i && ack_tmo_i;
  assign exit_tmo  = st_q[I_EXIT_WAIT] && sr_ack_i && ack_tmo_i;

  always_comb begin
    st_d = '0;
    unique case (1'b1)
      st_q[I_IDLE]:      if (req_i) st_d[I_IRQ_OFF] = 1'b1;
                         else       st_d[I_IDLE]    = 1'b1;
      st_q[I_IRQ_OFF]:   st_d[I_SR_REQ] = 1'b1;
      st_q[I_SR_REQ]:    st_d[I_SR_WAIT] = 1'b1;
      st_q[I_SR_WAIT]:   if (sr_ack_i)       st_d[I_SET_MODE] = 1'b1;
                         else if (ack_tmo_i) st_d[I_SR_EXIT]  = 1'b1;
                         else                st_d[I_SR_WAIT]  = 1'b1;
      st_q[I_SET_MODE]:  st_d[I_SWITCH] = 1'b1;
      st_q[I_SWITCH]:    st_d[I_SETTLE] = 1'b1;
      st_q[I_SETTLE]:    if (settle_hit_i) st_d[I_SR_EXIT] = 1'b1;
                         else              st_d[I_SETTLE]  = 1'b1;
      st_q[I_SR_EXIT]:   st_d[I_EXIT_WAIT] = 1'b1;
      st_q[I_EXIT_WAIT]: if (!sr_ack_i || ack_tmo_i) st_d[I_RESTORE]   = 1'b1;
                         else                        st_d[I_EXIT_WAIT] = 1'b1;
      st_q[I_RESTORE]:   st_d[I_IDLE] = 1'b1;
      default:           st_d[I_IDLE] = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= seq_state_t'(1) << I_IDLE;
      mode_q      <= '0;
      irq_saved_q <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        mode_q      <= mode_i;
        irq_saved_q <= irq_en_i;
      end
      if (entry_tmo || exit_tmo) err_q <= 1'b1;
    end
  end

  assign state_o     = st_q;
  assign mode_q_o    = mode_q;
  assign irq_saved_o = irq_saved_q;
  assign err_o       = err_q;

  // R12
  onehot_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(st_q) == 1);

  // R4
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st_q[I_IDLE] |=> $stable(mode_q));

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: rtl/clk_mode_seq.sv
module clk_mode_seq
  import cms_pkg::*;
#(
  parameter int SETTLE_CYCLES = 256,
  parameter int ACK_TIMEOUT   = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_i,
  input  logic [3:0]  req_mode_i,
  output logic        done_o,
  output logic        err_o,
  input  logic        irq_en_i,
  output logic        irq_en_o,
  output logic        sr_req_o,
  input  logic        sr_ack_i,
  output logic        mode_we_o,
  output logic [31:0] mode_wdata_o,
  input  logic [31:0] ctl_cur_i,
  output logic        ctl_we_o,
  output logic [31:0] ctl_wdata_o
);
  seq_state_t        st;
  logic [MODE_W-1:0] mode_q;
  logic              irq_saved;
  logic              settle_done;
  logic              ack_tmo;
  logic              ack_clr, ack_run;
  logic              settle_clr, settle_run;

  cms_seq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .mode_i       (req_mode_i),
    .irq_en_i     (irq_en_i),
    .sr_ack_i     (sr_ack_i),
    .settle_hit_i (settle_done),
    .ack_tmo_i    (ack_tmo),
    .state_o      (st),
    .mode_q_o     (mode_q),
    .irq_saved_o  (irq_saved),
    .err_o        (err_o)
  );

  assign ack_clr    = st[I_SR_REQ] || st[I_SR_EXIT];
  assign ack_run    = st[I_SR_WAIT] || st[I_EXIT_WAIT];
  assign settle_clr = st[I_SWITCH];
  assign settle_run = st[I_SETTLE];

  cms_cycle_timer #(.LIMIT(ACK_TIMEOUT)) u_ack_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (ack_clr),
    .en_i  (ack_run),
    .hit_o (ack_tmo)
  );

  cms_cycle_timer #(.LIMIT(SETTLE_CYCLES)) u_settle_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (settle_clr),
    .en_i  (settle_run),
    .hit_o (settle_done)
  );

  assign sr_req_o     = st[I_SR_REQ] || st[I_SR_WAIT] || st[I_SET_MODE] ||
                        st[I_SWITCH] || st[I_SETTLE];
  assign mode_we_o    = st[I_SET_MODE];
  assign mode_wdata_o = mode_word(mode_q);
  assign ctl_we_o     = st[I_SWITCH];
  assign ctl_wdata_o  = ctl_word(ctl_cur_i);
  assign done_o       = st[I_RESTORE];
  assign irq_en_o     = st[I_IDLE]    ? irq_en_i  :
                        st[I_RESTORE] ? irq_saved : 1'b0;

  // R2
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_req_o |-> !irq_en_o);

  // R3
  ack_before_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we_o |-> $past(sr_ack_i) && $past(sr_req_o));

  // R5
  sw_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we_o |=> !ctl_we_o);

  // R5
  sw_after_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we_o |-> $past(mode_we_o));

  // R6
  release_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_req_o) |-> ($past(settle_done) || err_o));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  done_after_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> !sr_ack_i);
endmodule

// File: tb/clk_mode_seq_bench.sv
module clk_mode_seq_bench;
  localparam int SETTLE = 256;
  localparam int TMO    = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [3:0]  req_mode = '0;
  logic        done, err, irq_in, irq_out, sr_req, sr_ack;
  logic        mode_we, ctl_we;
  logic [31:0] mode_wdata, ctl_cur, ctl_wdata;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  clk_mode_seq #(.SETTLE_CYCLES(SETTLE), .ACK_TIMEOUT(TMO)) u_clk_mode_seq (
    .clk(clk), .rst_n(rst_n), .req_i(req), .req_mode_i(req_mode),
    .done_o(done), .err_o(err), .irq_en_i(irq_in), .irq_en_o(irq_out),
    .sr_req_o(sr_req), .sr_ack_i(sr_ack), .mode_we_o(mode_we),
    .mode_wdata_o(mode_wdata), .ctl_cur_i(ctl_cur), .ctl_we_o(ctl_we),
    .ctl_wdata_o(ctl_wdata)
  );

  // SDRAM controller model: 0 normal, 1 ack stuck low, 2 ack stuck high once set
  int ack_dly = 2;
  int ack_mdl = 0;
  int dcnt = 0;
  initial sr_ack = 1'b0;
  always @(posedge clk) begin
    if (!rst_n) begin
      sr_ack <= 1'b0; dcnt <= 0;
    end else if (sr_req != sr_ack) begin
      if (dcnt >= ack_dly) begin
        dcnt <= 0;
        if (!(ack_mdl == 1 && sr_req) && !(ack_mdl == 2 && !sr_req))
          sr_ack <= sr_req;
      end else dcnt <= dcnt + 1;
    end else dcnt <= 0;
  end

  // Observation counters, sampled away from the active edge
  int n_done, n_ctl, n_mode, sr_hi_total, sr_hi_after_sw, irq_viol;
  int ack_bad_mode, done_with_ack, done_twice;
  logic sw_seen, prev_done, irq_at_done;
  logic [31:0] got_mode_w, got_ctl_w;

  task automatic clear_mon();
    n_done = 0; n_ctl = 0; n_mode = 0; sr_hi_total = 0; sr_hi_after_sw = 0;
    irq_viol = 0; ack_bad_mode = 0; done_with_ack = 0; done_twice = 0;
    sw_seen = 1'b0; irq_at_done = 1'bx; got_mode_w = '0; got_ctl_w = '0;
  endtask

  initial begin clear_mon(); prev_done = 1'b0; end

  always @(negedge clk) begin
    if (rst_n) begin
      if (sr_req) sr_hi_total++;
      if (sr_req && sw_seen) sr_hi_after_sw++;
      if (sr_req && irq_out) irq_viol++;
      if (mode_we) begin
        n_mode++; got_mode_w = mode_wdata;
        if (!sr_ack) ack_bad_mode++;
      end
      if (ctl_we) begin n_ctl++; got_ctl_w = ctl_wdata; sw_seen = 1'b1; end
      if (done) begin
        n_done++; irq_at_done = irq_out;
        if (sr_ack) done_with_ack++;
        if (prev_done) done_twice++;
      end
      prev_done = done;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Issue one request at a negedge; checks R2 on the following cycle.
  task automatic issue(input logic [3:0] m);
    req_mode = m; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk(irq_out == 1'b0, "R2", "irq gated after accept", irq_out, 0);
    chk(sr_req == 1'b0, "R2", "sr_req still low after accept", sr_req, 0);
  endtask

  task automatic wait_done();
    int i;
    for (i = 0; i < 3000 && n_done == 0; i++) @(negedge clk);
    chk(n_done != 0, "R7", "done seen", n_done, 1);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk(done == 0 && err == 0 && sr_req == 0, "R1", "idle outputs",
        {29'd0, done, err, sr_req}, 0);
    chk(mode_we == 0 && ctl_we == 0, "R1", "no strobes", {30'd0, mode_we, ctl_we}, 0);
    irq_in = 1'b0; #1;
    chk(irq_out == 1'b0, "R1", "irq follows 0", irq_out, 0);
    irq_in = 1'b1; #1;
    chk(irq_out == 1'b1, "R1", "irq follows 1", irq_out, 1);
  endtask

  task automatic t_normal(input logic [3:0] m, input int dly, input logic [31:0] cur);
    ack_dly = dly; ack_mdl = 0; ctl_cur = cur; irq_in = 1'b1;
    clear_mon();
    issue(m);
    req_mode = ~m;  // must be ignored (latched at accept)
    repeat (5) @(negedge clk);
    irq_in = 1'b0;  // saved value must still be restored
    wait_done();
    chk(got_mode_w == {4'h0, m, 24'h0}, "R4", "mode word", got_mode_w, {4'h0, m, 24'h0});
    chk(n_mode == 1, "R4", "one mode write", n_mode, 1);
    chk(ack_bad_mode == 0, "R3", "mode write only with ack", ack_bad_mode, 0);
    chk(n_ctl == 1, "R5", "one switch strobe", n_ctl, 1);
    chk(got_ctl_w == (cur | 32'h8000_0000), "R5", "ctl word", got_ctl_w, cur | 32'h8000_0000);
    chk(sr_hi_after_sw == SETTLE, "R6", "settle length", sr_hi_after_sw, SETTLE);
    chk(sr_req == 0, "R6", "self-refresh released", sr_req, 0);
    chk(irq_viol == 0, "R2", "irq low during self-refresh", irq_viol, 0);
    chk(done_with_ack == 0, "R7", "done after ack low", done_with_ack, 0);
    chk(done_twice == 0 && n_done == 1, "R7", "done single pulse", n_done, 1);
    chk(irq_at_done == 1'b1, "R7", "irq restored at done", irq_at_done, 1);
    chk(irq_out == 1'b0, "R7", "irq follows input after done", irq_out, 0);
  endtask

  task automatic t_busy();
    ack_dly = 1; ack_mdl = 0; ctl_cur = 32'h0; irq_in = 1'b1;
    clear_mon();
    issue(4'h3);
    repeat (40) @(negedge clk);
    req_mode = 4'hC; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    wait_done();
    repeat (SETTLE + 40) @(negedge clk);
    chk(n_done == 1, "R8", "busy request gives no second done", n_done, 1);
    chk(n_ctl == 1, "R8", "busy request gives no second strobe", n_ctl, 1);
    chk(got_mode_w == 32'h0300_0000, "R8", "mode from first request", got_mode_w, 32'h0300_0000);
  endtask

  task automatic t_entry_timeout();
    do_reset();
    ack_mdl = 1; ack_dly = 0; ctl_cur = 32'h5; irq_in = 1'b1;
    clear_mon();
    issue(4'h7);
    wait_done();
    chk(err == 1'b1, "R9", "err set on entry timeout", err, 1);
    chk(n_mode == 0 && n_ctl == 0, "R9", "no writes on abort", n_mode + n_ctl, 0);
    chk(sr_hi_total == TMO + 1, "R9", "sr_req high span", sr_hi_total, TMO + 1);
    chk(irq_at_done == 1'b1, "R9", "irq restored on abort", irq_at_done, 1);
  endtask

  task automatic t_exit_timeout();
    do_reset();
    ack_mdl = 2; ack_dly = 0; ctl_cur = 32'h0; irq_in = 1'b0;
    clear_mon();
    chk(err == 1'b0, "R10", "err clear after reset", err, 0);
    issue(4'h1);
    wait_done();
    chk(err == 1'b1, "R10", "err set on exit timeout", err, 1);
    chk(n_ctl == 1 && n_done == 1, "R10", "switch done then abort", n_ctl, 1);
    chk(irq_at_done == 1'b0, "R10", "restored irq is saved 0", irq_at_done, 0);
    ack_mdl = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_sticky();
    t_normal(4'h9, 2, 32'h0000_00FF);
    chk(err == 1'b1, "R11", "err stays set after good run", err, 1);
  endtask

  initial begin
    irq_in = 1'b1; ctl_cur = '0;
    t_reset();
    t_normal(4'hA, 3, 32'h1234_5678);
    t_normal(4'h5, 0, 32'hFFFF_FFFF);
    t_normal(4'hF, 20, 32'h0000_0000);
    t_busy();
    t_entry_timeout();
    t_exit_timeout();
    t_sticky();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule